// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Core

This block is a purely combinational arithmetic core. It adds or subtracts two operand buses and produces the result together with four condition flags: negative, zero, carry and overflow. It is meant to sit behind both the immediate and the register forms of an add/subtract datapath. Operand decode, shifting, extension and register access all stay upstream of it.

A width select picks either full-width or half-width operation. In half-width mode only the low half of each operand takes part. The result is zero-extended onto the full output bus, and every flag describes the half-width operation alone. For subtraction, carry is the "no borrow" indication: it is set when the first operand is not below the second as an unsigned number.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_en`=0 and `wide_en`=1, `sum_out` equals `op_a + op_b` modulo 2^64.
- R2: With `sub_en`=1 and `wide_en`=1, `sum_out` equals `op_a - op_b` modulo 2^64.
- R3: With `wide_en`=0, only bits [31:0] of each operand are used. `sum_out[63:32]` is zero, `sum_out[31:0]` is the 32-bit sum or difference, and the upper operand bits have no effect on any output.
- R4: `flag_n` equals bit 63 of the result when `wide_en`=1 and bit 31 when `wide_en`=0.
- R5: `flag_z` is 1 exactly when the result at the selected width is all zeros.
- R6: For addition, `flag_c` is the carry out of bit 63 (wide) or bit 31 (narrow).
- R7: For subtraction, `flag_c` is 1 exactly when `op_a >= op_b` as unsigned numbers at the selected width.
- R8: For addition, `flag_v` is 1 exactly when both operands have the same sign bit at the selected width and the result sign differs from it.
- R9: For subtraction, `flag_v` is 1 exactly when the operand sign bits differ at the selected width and the result sign differs from that of `op_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand (minuend for subtraction) |
| op_b | input | 64 | Second operand (subtrahend for subtraction) |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| wide_en | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit operation |
| sum_out | output | 64 | Result, zero-extended in 32-bit mode |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow for subtraction) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The block holds no state, so any fault shows on the ports in the same evaluation in which the faulty inputs are applied. A wrong operand mask or carry tap shows up as a wrong carry or a non-zero upper half in narrow mode. The clearest stimuli are the all-ones plus one and the borrow cases. A wrong sign tap or overflow term shows up as mismatched N and V at the signed extremes: INT_MIN minus one, INT_MAX plus one, and the same-sign additions at each width.

// File: rtl/addsub_flags_pkg.sv
package addsub_flags_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Overflow on a true addition of a and addend: equal input signs, different result sign.
  function automatic logic add_ovf(input logic a_top, input logic addend_top, input logic r_top);
    return (r_top ^ a_top) & ~(a_top ^ addend_top);
  endfunction

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              sub,
  input  logic              wide,
  output logic [DATA_W-1:0] a_eff,
  output logic [DATA_W-1:0] b_eff,
  output logic              carry_in
);
  localparam int UPPER_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] b_signed;

  assign width_mask = wide ? {DATA_W{1'b1}} : {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};
  assign b_signed   = sub ? ~b_in : b_in;
  assign a_eff      = a_in & width_mask;
  assign b_eff      = b_signed & width_mask;
  assign carry_in   = sub;
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W:0]   sum_ext
);
  assign sum_ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_flags_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              wide,
  input  logic [DATA_W-1:0] a_eff,
  input  logic [DATA_W-1:0] b_eff,
  input  logic [DATA_W:0]   sum_ext,
  output logic [DATA_W-1:0] result,
  output nzcv_t             flags
);
  localparam int UPPER_W = DATA_W - NARROW_W;

  logic a_top, b_top, r_top, carry_tap;

  assign result    = wide ? sum_ext[DATA_W-1:0]
                          : {{UPPER_W{1'b0}}, sum_ext[NARROW_W-1:0]};
  assign carry_tap = wide ? sum_ext[DATA_W] : sum_ext[NARROW_W];
  assign a_top     = wide ? a_eff[DATA_W-1]  : a_eff[NARROW_W-1];
  assign b_top     = wide ? b_eff[DATA_W-1]  : b_eff[NARROW_W-1];
  assign r_top     = wide ? result[DATA_W-1] : result[NARROW_W-1];

  always_comb begin
    flags.n = r_top;
    flags.z = (result == '0);
    flags.c = carry_tap;
    flags.v = add_ovf(a_top, b_top, r_top);
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_flags_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        sub_en,
  input  logic        wide_en,
  output logic [63:0] sum_out,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_v
);
  logic [DATA_W-1:0] a_eff_w, b_eff_w, result_w;
  logic              carry_in_w;
  logic [DATA_W:0]   sum_ext_w;
  nzcv_t             flags_w;

  addsub_operand_prep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_prep (
    .a_in(op_a), .b_in(op_b), .sub(sub_en), .wide(wide_en),
    .a_eff(a_eff_w), .b_eff(b_eff_w), .carry_in(carry_in_w)
  );

  addsub_adder #(.DATA_W(DATA_W)) u_adder (
    .a(a_eff_w), .b(b_eff_w), .cin(carry_in_w), .sum_ext(sum_ext_w)
  );

  addsub_flag_unit #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
    .wide(wide_en), .a_eff(a_eff_w), .b_eff(b_eff_w), .sum_ext(sum_ext_w),
    .result(result_w), .flags(flags_w)
  );

  assign sum_out = result_w;
  assign flag_n  = flags_w.n;
  assign flag_z  = flags_w.z;
  assign flag_c  = flags_w.c;
  assign flag_v  = flags_w.v;

  logic inputs_known;
  assign inputs_known = !$isunknown({op_a, op_b, sub_en, wide_en});

  always_comb begin
    if (inputs_known) begin
      // R3
      narrow_upper_chk: assert final (wide_en || sum_out[DATA_W-1:NARROW_W] == '0);
      // R7
      sub_carry_chk: assert final (!sub_en || flag_c == (wide_en ? (op_a >= op_b)
                                   : (op_a[NARROW_W-1:0] >= op_b[NARROW_W-1:0])));
      // R8
      no_overflow_chk: assert final (sub_en || !(wide_en ? (op_a[DATA_W-1] != op_b[DATA_W-1])
                                     : (op_a[NARROW_W-1] != op_b[NARROW_W-1])) || !flag_v);
      // R5
      sub_zero_chk: assert final (!sub_en || !flag_z || (wide_en ? (op_a == op_b)
                                  : (op_a[NARROW_W-1:0] == op_b[NARROW_W-1:0])));
      // R4
      sub_sign_chk: assert final (!sub_en || flag_v || flag_n == (wide_en
                                  ? ($signed(op_a) < $signed(op_b))
                                  : ($signed(op_a[NARROW_W-1:0]) < $signed(op_b[NARROW_W-1:0]))));
    end
  end
endmodule

// File: tb/test_addsub_flags.sv
module test_addsub_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        sub_en = 1'b0, wide_en = 1'b1;
  logic [63:0] sum_out;
  logic        flag_n, flag_z, flag_c, flag_v;
  int          checks = 0, fails = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  addsub_flags i_addsub_flags (
    .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .wide_en(wide_en),
    .sum_out(sum_out), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // Entry: {sub, wide, a, b}
  localparam int NV = 16;
  localparam logic [129:0] VEC [NV] = '{
    {1'b1, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    {1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {1'b0, 1'b1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003},
    {1'b1, 1'b1, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005},
    {1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
    {1'b1, 1'b1, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b1, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000},
    {1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001},
    {1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001},
    {1'b0, 1'b0, 64'hABCD_0000_0000_0005, 64'h0123_4567_0000_0003},
    {1'b1, 1'b0, 64'hFFFF_FFFF_0000_0003, 64'h0000_0000_0000_0005},
    {1'b1, 1'b0, 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_FFFF_FFFF}
  };

  // Reference model: returns {result, n, z, c, v}, overflow via sign-extended arithmetic
  function automatic logic [67:0] model(input logic s, input logic w,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [64:0] u64; logic [65:0] sg64;
    logic [32:0] u32; logic [33:0] sg32;
    logic [63:0] r; logic n, z, c, v;
    if (w) begin
      if (s) begin
        u64 = {1'b0, a} - {1'b0, b}; c = (a >= b);
        sg64 = {{2{a[63]}}, a} - {{2{b[63]}}, b};
      end else begin
        u64 = {1'b0, a} + {1'b0, b}; c = u64[64];
        sg64 = {{2{a[63]}}, a} + {{2{b[63]}}, b};
      end
      r = u64[63:0]; n = r[63]; v = (sg64[64] != sg64[63]);
    end else begin
      if (s) begin
        u32 = {1'b0, a[31:0]} - {1'b0, b[31:0]}; c = (a[31:0] >= b[31:0]);
        sg32 = {{2{a[31]}}, a[31:0]} - {{2{b[31]}}, b[31:0]};
      end else begin
        u32 = {1'b0, a[31:0]} + {1'b0, b[31:0]}; c = u32[32];
        sg32 = {{2{a[31]}}, a[31:0]} + {{2{b[31]}}, b[31:0]};
      end
      r = {32'h0, u32[31:0]}; n = r[31]; v = (sg32[32] != sg32[31]);
    end
    z = (r == 64'h0);
    return {r, n, z, c, v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic w, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    sub_en = s; wide_en = w; op_a = a; op_b = b;
    #2;
  endtask

  task automatic check_all(input logic s, input logic w, input logic [63:0] a, input logic [63:0] b);
    logic [67:0] e;
    e = model(s, w, a, b);
    chk(w ? (s ? "R2 result" : "R1 result") : "R3 result", sum_out, e[67:4]);
    chk("R4 N", {63'h0, flag_n}, {63'h0, e[3]});
    chk("R5 Z", {63'h0, flag_z}, {63'h0, e[2]});
    chk(s ? "R7 C" : "R6 C", {63'h0, flag_c}, {63'h0, e[1]});
    chk(s ? "R9 V" : "R8 V", {63'h0, flag_v}, {63'h0, e[0]});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    logic [67:0] first_out;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: zero operands, wide add -> zero result, Z set (R5), others clear
    apply(1'b0, 1'b1, 64'h0, 64'h0);
    chk("R1 reset result", sum_out, 64'h0);
    chk("R5 reset Z", {63'h0, flag_z}, 64'h1);
    chk("R6 reset C", {63'h0, flag_c}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][129], VEC[i][128], VEC[i][127:64], VEC[i][63:0]);
      check_all(VEC[i][129], VEC[i][128], VEC[i][127:64], VEC[i][63:0]);
    end

    // R3: upper operand bits in narrow mode leave every output unchanged
    apply(1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001);
    first_out = {sum_out, flag_n, flag_z, flag_c, flag_v};
    apply(1'b1, 1'b0, 64'h5A5A_A5A5_8000_0000, 64'hFFFF_FFFF_0000_0001);
    chk("R3 upper ignored", {sum_out, flag_n, flag_z, flag_c, flag_v} ^ first_out[63:0] ^
        {sum_out[59:0], flag_n, flag_z, flag_c, flag_v}, {sum_out[59:0], flag_n, flag_z, flag_c, flag_v});
    chk("R3 upper ignored result", sum_out, first_out[67:4]);
    chk("R3 upper ignored flags", {60'h0, flag_n, flag_z, flag_c, flag_v}, {60'h0, first_out[3:0]});

    // R7 boundary: equal operands narrow with differing upper bits -> C=1, Z=1
    apply(1'b1, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7 equal narrow C", {63'h0, flag_c}, 64'h1);
    chk("R5 equal narrow Z", {63'h0, flag_z}, 64'h1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule